// File: doc/BRIEF.md
# Four-Section Cubic Fit Accumulator

This block characterises the transfer curve of a digital-to-analog converter under test with a cubic polynomial. After a start pulse it walks the converter through every input code from zero to full scale. It holds each code until an external measuring converter reports a settled, decimated reading through a valid strobe. The readings are added into one of four running sums, one for each quarter of the code range.

When the last code has been measured, the block turns the four sums into four polynomial coefficients. These are offset, gain, second order and third order. Each coefficient is a fixed signed combination of the sums. A single shared multiply-accumulate path computes the combinations in sixteen sequential steps, four for each coefficient. A one-cycle done pulse marks the moment the four coefficient outputs are all final.

The polynomial uses a position variable t measured in half-section units about mid-range, so the four section centres sit at t = -3, -1, +1, +3. Each coefficient output is the integer numerator of the fitted coefficient, with an implied scale of 1/(48·L). Here L = 2^(CODE_W-2) is the section length. The measuring converter and its decimation filter are outside the block.

Top module: `pf_cubic_fit`

## Requirements
- R1: After reset, dac_code is 0, done is 0 and all four coefficient outputs are 0.
- R2: A start pulse while idle begins a sweep at code 0 and clears all four section sums.
- R3: During a sweep, dac_code holds until meas_valid is seen high on a clock edge, then advances by one. After full scale it returns to 0 and the sweep ends. While idle, dac_code is 0.
- R4: The reading taken at code c is added to the sum of section c / L, with L = 2^(CODE_W-2). The section index is the top two code bits.
- R5: With section sums S0..S3, the outputs are: coef0 = 27(S1+S2) - 3(S0+S3); coef1 = 27(S2-S1) - (S3-S0); coef2 = 3(S0+S3) - 3(S1+S2); coef3 = 3(S1-S2) + (S3-S0). All are exact signed integers.
- R6: done is high for exactly one cycle per run. It rises on the 16th clock edge after the edge that accepts the last reading, and all four coefficient outputs hold their final values in that cycle.
- R7: Coefficient outputs change only while the combination steps run. From done until the next run's combination they hold.
- R8: start has no effect while a sweep or a combination is in progress.
- R9: meas_valid and meas_data have no effect outside a sweep. They change neither dac_code nor any section sum.
- R10: Full-scale readings (all ones) at every code produce exact results with no overflow of sums or coefficients.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a characterisation run (idle only) |
| dac_code | output | CODE_W | Code applied to the converter under test |
| meas_valid | input | 1 | Reading for the current code is available |
| meas_data | input | MEAS_W | Unsigned decimated reading |
| done | output | 1 | One-cycle pulse: coefficients are final |
| coef0 | output | MEAS_W+CODE_W+5 | Offset numerator, signed |
| coef1 | output | MEAS_W+CODE_W+5 | Gain numerator, signed |
| coef2 | output | MEAS_W+CODE_W+5 | Second-order numerator, signed |
| coef3 | output | MEAS_W+CODE_W+5 | Third-order numerator, signed |

## Verification
The bound checker watches the code sequencing on every cycle. It checks that the code is held without a strobe and steps by one with a strobe. It checks that start is ignored mid-sweep and mid-combination, that the code stays at zero while idle, that done is a single pulse following the combination, and that the coefficients stay frozen outside the combination phase.

The arithmetic cannot be seen cycle by cycle and is shown only by the bench scenarios. These cover the routing of readings into the right quarter, the weighted combinations and the full-scale range. Constant, linear, quadratic, cubic, random, zero and all-ones curves are compared against sums and coefficients that the bench computes in an even/odd factored form. Stray strobes and start pulses are also injected while the block is idle or combining.

// File: rtl/pf_fit_pkg.sv
package pf_fit_pkg;

  typedef enum logic [1:0] {
    PF_IDLE    = 2'd0,
    PF_SWEEP   = 2'd1,
    PF_COMBINE = 2'd2
  } pf_state_e;

  // Signed weight applied to section sum 'sec' when forming coefficient 'coef'.
  // Derived from an exact cubic through section means at t = -3, -1, +1, +3,
  // all coefficients sharing the common denominator 48.
  function automatic logic signed [7:0] fit_weight(input logic [1:0] coef,
                                                   input logic [1:0] sec);
    logic signed [7:0] w;
    unique case ({coef, sec})
      4'b00_00: w = -8'sd3;   4'b00_01: w = 8'sd27;
      4'b00_10: w = 8'sd27;   4'b00_11: w = -8'sd3;
      4'b01_00: w = 8'sd1;    4'b01_01: w = -8'sd27;
      4'b01_10: w = 8'sd27;   4'b01_11: w = -8'sd1;
      4'b10_00: w = 8'sd3;    4'b10_01: w = -8'sd3;
      4'b10_10: w = -8'sd3;   4'b10_11: w = 8'sd3;
      4'b11_00: w = -8'sd1;   4'b11_01: w = 8'sd3;
      4'b11_10: w = -8'sd3;   4'b11_11: w = 8'sd1;
      default:  w = 8'sd0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/pf_sweep_ctrl.sv
module pf_sweep_ctrl
  import pf_fit_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              meas_valid,
  input  logic              mac_last,
  output logic [CODE_W-1:0] dac_code,
  output logic              sweeping,
  output logic              combining,
  output logic              sweep_clear,
  output logic              meas_take
);

  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  pf_state_e state_q;
  logic [CODE_W-1:0] code_q;

  assign sweeping    = (state_q == PF_SWEEP);
  assign combining   = (state_q == PF_COMBINE);
  assign sweep_clear = (state_q == PF_IDLE) && start;
  assign meas_take   = sweeping && meas_valid;
  assign dac_code    = code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PF_IDLE;
      code_q  <= '0;
    end else begin
      unique case (state_q)
        PF_IDLE: begin
          code_q <= '0;
          if (start) state_q <= PF_SWEEP;
        end
        PF_SWEEP: begin
          if (meas_valid) begin
            code_q <= code_q + CODE_W'(1);
            if (code_q == CODE_MAX) state_q <= PF_COMBINE;
          end
        end
        PF_COMBINE: begin
          if (mac_last) state_q <= PF_IDLE;
        end
        default: state_q <= PF_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pf_section_acc.sv
module pf_section_acc #(
  parameter int MEAS_W = 16,
  parameter int SUM_W  = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic [1:0]        section,
  input  logic [MEAS_W-1:0] meas,
  output logic [SUM_W-1:0]  sums [4]
);

  for (genvar g = 0; g < 4; g++) begin : g_sec
    logic [SUM_W-1:0] sum_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sum_q <= '0;
      else if (clear)
        sum_q <= '0;
      else if (take && (section == 2'(g)))
        sum_q <= sum_q + {{(SUM_W-MEAS_W){1'b0}}, meas};
    end
    assign sums[g] = sum_q;
  end

endmodule

// File: rtl/pf_combiner.sv
module pf_combiner
  import pf_fit_pkg::*;
#(
  parameter int SUM_W  = 22,
  parameter int COEF_W = 29
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [SUM_W-1:0]         sums [4],
  output logic signed [COEF_W-1:0] coefs [4],
  output logic                     mac_last,
  output logic                     done
);

  logic [3:0]               step_q;
  logic signed [COEF_W-1:0] acc_q;
  logic signed [COEF_W-1:0] w_ext, s_ext, prod, total;
  logic signed [COEF_W-1:0] coef_q [4];

  // One shared multiplier: weight(coef=step[3:2], sec=step[1:0]) * sum
  assign w_ext    = COEF_W'(fit_weight(step_q[3:2], step_q[1:0]));
  assign s_ext    = $signed({{(COEF_W-SUM_W){1'b0}}, sums[step_q[1:0]]});
  assign prod     = w_ext * s_ext;
  assign total    = acc_q + prod;
  assign mac_last = en && (step_q == 4'hF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      acc_q  <= '0;
      done   <= 1'b0;
      for (int i = 0; i < 4; i++) coef_q[i] <= '0;
    end else begin
      done <= mac_last;
      if (!en) begin
        step_q <= '0;
        acc_q  <= '0;
      end else begin
        step_q <= step_q + 4'd1;
        if (step_q[1:0] == 2'd3) begin
          coef_q[step_q[3:2]] <= total;
          acc_q               <= '0;
        end else begin
          acc_q <= total;
        end
      end
    end
  end

  assign coefs = coef_q;

endmodule

// File: rtl/pf_cubic_fit.sv
module pf_cubic_fit #(
  parameter int CODE_W = 8,
  parameter int MEAS_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  output logic [CODE_W-1:0]                 dac_code,
  input  logic                              meas_valid,
  input  logic [MEAS_W-1:0]                 meas_data,
  output logic                              done,
  output logic signed [MEAS_W+CODE_W+4:0]   coef0,
  output logic signed [MEAS_W+CODE_W+4:0]   coef1,
  output logic signed [MEAS_W+CODE_W+4:0]   coef2,
  output logic signed [MEAS_W+CODE_W+4:0]   coef3
);

  localparam int SEC_W  = CODE_W - 2;           // log2 of section length
  localparam int SUM_W  = MEAS_W + SEC_W;       // exact section sum
  localparam int COEF_W = SUM_W + 7;            // sign + weight magnitude < 64

  logic sweeping, combining, sweep_clear, meas_take, mac_last;
  logic [SUM_W-1:0]         sums  [4];
  logic signed [COEF_W-1:0] coefs [4];

  pf_sweep_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk, .rst_n, .start, .meas_valid, .mac_last,
    .dac_code, .sweeping, .combining, .sweep_clear, .meas_take
  );

  pf_section_acc #(.MEAS_W(MEAS_W), .SUM_W(SUM_W)) u_acc (
    .clk, .rst_n,
    .clear   (sweep_clear),
    .take    (meas_take),
    .section (dac_code[CODE_W-1 -: 2]),
    .meas    (meas_data),
    .sums    (sums)
  );

  pf_combiner #(.SUM_W(SUM_W), .COEF_W(COEF_W)) u_comb (
    .clk, .rst_n,
    .en       (combining),
    .sums     (sums),
    .coefs    (coefs),
    .mac_last (mac_last),
    .done     (done)
  );

  assign coef0 = coefs[0];
  assign coef1 = coefs[1];
  assign coef2 = coefs[2];
  assign coef3 = coefs[3];

endmodule

// File: rtl/pf_cubic_fit_chk.sv
module pf_cubic_fit_chk #(
  parameter int CODE_W = 8,
  parameter int CW     = 29
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic                  meas_valid,
  input logic [CODE_W-1:0]     dac_code,
  input logic                  done,
  input logic signed [CW-1:0]  coef0,
  input logic signed [CW-1:0]  coef1,
  input logic signed [CW-1:0]  coef2,
  input logic signed [CW-1:0]  coef3,
  input logic                  sweeping,
  input logic                  combining
);

  a_r3_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sweeping && !meas_valid) |=> $stable(dac_code));

  a_r3_code_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sweeping && meas_valid) |=> (dac_code == CODE_W'($past(dac_code) + 1'b1)));

  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!sweeping && !combining) |-> (dac_code == '0));

  a_r8_start_sweep: assert property (@(posedge clk) disable iff (!rst_n)
    (sweeping && start && !meas_valid) |=> (sweeping && $stable(dac_code)));

  a_r8_start_combine: assert property (@(posedge clk) disable iff (!rst_n)
    (combining && start) |=> !sweeping);

  a_r9_idle_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (!sweeping && !combining && !start && meas_valid) |=> (!sweeping && dac_code == '0));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_after_combine: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!combining && !sweeping && $past(combining)));

  a_r7_coef_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !combining |=> ($stable(coef0) && $stable(coef1) && $stable(coef2) && $stable(coef3)));

endmodule

bind pf_cubic_fit pf_cubic_fit_chk #(.CODE_W(CODE_W), .CW(MEAS_W+CODE_W+5)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .meas_valid (meas_valid),
  .dac_code   (dac_code),
  .done       (done),
  .coef0      (coef0),
  .coef1      (coef1),
  .coef2      (coef2),
  .coef3      (coef3),
  .sweeping   (sweeping),
  .combining  (combining)
);

// File: tb/tb_pf_cubic_fit.sv
module tb_pf_cubic_fit;

  localparam int CODE_W = 8;
  localparam int MEAS_W = 16;
  localparam int CW     = MEAS_W + CODE_W + 5;
  localparam int NCODES = 1 << CODE_W;
  localparam int SECLEN = NCODES / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic meas_valid = 1'b0;
  logic [MEAS_W-1:0] meas_data = '0;
  logic [CODE_W-1:0] dac_code;
  logic done;
  logic signed [CW-1:0] coef0, coef1, coef2, coef3;

  int checks = 0;
  int failures = 0;
  int pat [NCODES];

  always #10 clk = ~clk;   // 50 MHz

  pf_cubic_fit #(.CODE_W(CODE_W), .MEAS_W(MEAS_W)) dut (
    .clk, .rst_n, .start, .dac_code, .meas_valid, .meas_data,
    .done, .coef0, .coef1, .coef2, .coef3
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected coefficients, factored into even and odd parts of the sums.
  function automatic longint exp_coef(input int idx);
    longint s [4];
    longint ev_out, ev_in, od_out, od_in;
    for (int k = 0; k < 4; k++) s[k] = 0;
    for (int c = 0; c < NCODES; c++) s[c / SECLEN] += longint'(pat[c]);
    ev_out = s[0] + s[3];  ev_in = s[1] + s[2];
    od_out = s[3] - s[0];  od_in = s[2] - s[1];
    case (idx)
      0:       return 3 * (9 * ev_in - ev_out);
      1:       return 27 * od_in - od_out;
      2:       return 3 * (ev_out - ev_in);
      default: return od_out - 3 * od_in;
    endcase
  endfunction

  task automatic fill(input int mode);
    for (int c = 0; c < NCODES; c++) begin
      case (mode)
        0: pat[c] = 1000;
        1: pat[c] = c * 37 + 5;
        2: pat[c] = c * c;
        3: pat[c] = int'($urandom % 65536);
        4: pat[c] = 65535;
        5: pat[c] = 0;
        default: pat[c] = ((c - 128) * (c - 128) * (c - 128)) / 64 + 32768;
      endcase
    end
  endtask

  task automatic check_coefs(input string tag);
    chk(longint'(coef0) == exp_coef(0), {tag, " R5 coef0"}, longint'(coef0), exp_coef(0));
    chk(longint'(coef1) == exp_coef(1), {tag, " R5 coef1"}, longint'(coef1), exp_coef(1));
    chk(longint'(coef2) == exp_coef(2), {tag, " R5 coef2"}, longint'(coef2), exp_coef(2));
    chk(longint'(coef3) == exp_coef(3), {tag, " R5 coef3"}, longint'(coef3), exp_coef(3));
  endtask

  // One full run; inj_start pulses start mid-sweep, noisy drives strobes and start while combining.
  task automatic run(input string tag, input bit inj_start, input bit noisy);
    int bad_code;
    int lat;
    bad_code = -1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int c = 0; c < NCODES; c++) begin
      int gap;
      gap = int'($urandom % 4);
      for (int g = 0; g < gap; g++) begin
        if (inj_start && c == 100 && g == 0) start = 1'b1;   // R8
        @(negedge clk);
        start = 1'b0;
      end
      if (int'(dac_code) != c && bad_code < 0) bad_code = int'(dac_code) + 1000 * c;
      meas_valid = 1'b1;
      meas_data  = MEAS_W'(pat[c]);
      @(negedge clk);
      meas_valid = 1'b0;
    end
    chk(bad_code < 0, {tag, " R3/R4 code order"}, bad_code, -1);
    lat = 0;
    while (!done && lat < 100) begin
      if (noisy) begin                                         // R9, R8
        meas_valid = 1'($urandom % 2);
        meas_data  = MEAS_W'($urandom);
        start      = 1'($urandom % 2);
      end
      @(negedge clk);
      lat++;
    end
    meas_valid = 1'b0;
    start      = 1'b0;
    chk(lat == 16, {tag, " R6 done latency"}, lat, 16);
    check_coefs(tag);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R6 done single cycle"}, longint'(done), 0);
    chk(dac_code == '0, {tag, " R3 code back to zero"}, longint'(dac_code), 0);
  endtask

  // Strobes while idle must leave the code and coefficients untouched.
  task automatic idle_noise(input string tag);
    longint c0, c3;
    bit ok;
    c0 = longint'(coef0);
    c3 = longint'(coef3);
    ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      meas_valid = 1'b1;
      meas_data  = MEAS_W'($urandom);
      @(negedge clk);
      if (dac_code != '0) ok = 1'b0;
    end
    meas_valid = 1'b0;
    chk(ok, {tag, " R9 idle code"}, longint'(dac_code), 0);
    chk(longint'(coef0) == c0 && longint'(coef3) == c3, {tag, " R7 idle hold"},
        longint'(coef0), c0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dac_code == '0, "R1 reset code", longint'(dac_code), 0);
    chk(done == 1'b0, "R1 reset done", longint'(done), 0);
    chk(coef0 == '0 && coef1 == '0 && coef2 == '0 && coef3 == '0, "R1 reset coefs",
        longint'(coef0), 0);
    rst_n = 1'b1;
    @(negedge clk);
    idle_noise("pre");

    fill(0); run("const R2", 1'b0, 1'b0);
    fill(1); run("linear", 1'b1, 1'b0);
    idle_noise("post-linear");
    fill(2); run("quadratic", 1'b0, 1'b1);
    fill(3); run("random", 1'b1, 1'b1);
    fill(4); run("fullscale R10", 1'b0, 1'b0);
    fill(5); run("zero R2", 1'b0, 1'b1);
    fill(6); run("cubic", 1'b0, 1'b0);
    fill(3); run("random2", 1'b0, 1'b1);
    idle_noise("end");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule